// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Target Engine

This block is the bus-facing half of a two-wire (I2C) serial EEPROM. It samples the bus clock and data lines on a faster system clock and recognises start and stop conditions. It shifts bytes in and out most significant bit first. It answers only to its own device select code, and it pulls the shared data line low for acknowledges and for read data bits. The storage array, the page buffer and the self-timed programming timer are outside the block.

A write transaction carries a 16-bit byte address in two bytes, followed by data bytes. Each data byte goes out on a write stream together with its target address. The stream has a valid/ready pair, and there is no back-pressure on the bus side, because clock stretching is not used. `wr_valid_o` is high for exactly one system cycle per received data byte. A byte counts as taken only if `wr_ready_i` is high in that same cycle. Otherwise the byte is dropped and the bus master gets a no-acknowledge. `wr_commit_o` tells the programming timer to start. While that timer reports busy, every select is refused, so a master can poll for completion.

Reads take their data from `rd_data_i`, which must show the byte at `rd_addr_o` no more than four system cycles after that address changes. Random reads are a write select plus address, then a repeated start. Current-address reads start straight from a read select. Sequential reads continue while the master acknowledges.

Top module: `eep_i2c_target`

## Requirements
- R1: A start (SDA falls while SCL is high) makes the engine expect a select byte from any state. A stop (SDA rises while SCL is high) returns it to idle with SDA released. In idle, bytes sent without a new start get no acknowledge.
- R2: `sda_low_o` changes only while the synchronized SCL is low, except when a start or stop releases it.
- R3: The select byte is received MSB first. Bits 7..4 must equal the device type 1010. Bits 3..1 must equal `chip_en_i[2:0]`. Bit 0 selects read (1) or write (0). On a match the engine acknowledges in the ninth bit slot. On a mismatch it does not acknowledge and ignores the bus until the next start.
- R4: After a write select, two address bytes follow, high byte first, and each is acknowledged. The address becomes the low ADDR_W bits of the 16-bit value.
- R5: Each write data byte is offered with `wr_valid_o` for one cycle, carrying `wr_data_o` and `wr_addr_o`. It is acknowledged only if `wr_ready_i` is high in that cycle. After each accepted byte, the low PAGE_W address bits increment and wrap, and the upper bits stay unchanged.
- R6: With `wr_protect_i` high, select and address bytes are still acknowledged. Data bytes are neither acknowledged nor offered.
- R7: With `wcycle_busy_i` high when a select byte completes, that select is not acknowledged, whether it is a read or a write. The engine then goes idle.
- R8: `wr_commit_o` pulses for one cycle on a stop that directly follows the acknowledge slot of an accepted data byte. A stop at any other point gives no pulse.
- R9: Read bytes come from `rd_data_i` MSB first. The address increments over the full ADDR_W width after each byte and rolls over from all-ones to zero. Reading continues while the master acknowledges. A master no-acknowledge releases SDA and sends the engine to idle.
- R10: A read select after a repeated start reads from the address set by the preceding write select. A read select after a plain start reads from the current address.
- R11: A start in the middle of a data byte discards the partial byte and leaves the address unchanged. Nothing is offered on the write stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| sda_low_o | output | 1 | 1 pulls the data line low; 0 releases it |
| chip_en_i | input | 3 | Strapped address compared with select bits 3..1 |
| wr_protect_i | input | 1 | 1 blocks data bytes of writes |
| wcycle_busy_i | input | 1 | 1 while the self-timed programming cycle runs |
| wr_valid_o | output | 1 | One-cycle offer of a received write byte |
| wr_ready_i | input | 1 | Page buffer accepts the offered byte this cycle |
| wr_addr_o | output | ADDR_W | Array address of the offered byte |
| wr_data_o | output | 8 | Offered write byte |
| wr_commit_o | output | 1 | One-cycle request to start programming |
| rd_addr_o | output | ADDR_W | Address of the next byte to read |
| rd_data_i | input | 8 | Array byte at `rd_addr_o` |

## Verification
Every bus edge goes through a two-flop synchronizer and one edge register. The engine therefore reacts three system cycles after an SCL or SDA transition, and its registered outputs change in the fourth cycle. The bench master holds each bus phase for eight system cycles. It samples the acknowledge and read bits in the middle of the SCL high phase, which is well after the engine has settled. Write-stream offers, address wrap and commit pulses are captured at the clock edge where they occur. They are compared after the transaction's stop against addresses and data that the bench computes arithmetically.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RD
  } eep_state_e;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic              scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_q <= scl_p[STAGES-1];
      sda_q <= sda_p[STAGES-1];
    end
  end

  assign scl_o      = scl_p[STAGES-1];
  assign sda_o      = sda_p[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr #(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc_page,
  input  logic              inc_full,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] FULL_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] addr_q, page_nxt;

  generate
    if (PAGE_W >= ADDR_W) begin : g_flat
      assign page_nxt = addr_q + FULL_ONE;
    end else begin : g_row
      localparam logic [PAGE_W-1:0] PAGE_ONE = PAGE_W'(1);
      assign page_nxt = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + PAGE_ONE};

      assert_page_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_page && !load) |=> addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        addr_q <= '0;
    else if (load)     addr_q <= load_val;
    else if (inc_page) addr_q <= page_nxt;
    else if (inc_full) addr_q <= addr_q + FULL_ONE;
  end

  assign addr_o = addr_q;

  assert_read_rollover_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_full && !load && !inc_page && (&addr_q)) |=> addr_q == '0);
endmodule

// File: rtl/eep_i2c_target.sv
module eep_i2c_target #(
  parameter int         ADDR_W      = 15,
  parameter int         PAGE_W      = 6,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_TYPE    = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_low_o,
  input  logic [2:0]        chip_en_i,
  input  logic              wr_protect_i,
  input  logic              wcycle_busy_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i
);
  import eep_pkg::*;

  logic scl_s, sda_s, scl_rise, scl_fall, start_w, stop_w;

  eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start_w), .stop_o(stop_w)
  );

  eep_state_e  st_q, nxt_q, target;
  logic [3:0]  bit_q;
  logic [7:0]  rx_q, tx_q, ahi_q, wdat_q;
  logic [7:0]  rx_next;
  logic        ack_q, sda_low_q, wvalid_q, commit_q, armed_q, mack_q;
  logic        sel_match;
  logic        ld, inc_page, inc_full;
  logic [ADDR_W-1:0] addr;

  assign rx_next   = {rx_q[6:0], sda_s};
  assign sel_match = (rx_next[7:4] == DEV_TYPE) && (rx_next[3:1] == chip_en_i) && !wcycle_busy_i;

  wire   live      = !start_w && !stop_w && (st_q != ST_IDLE);
  assign ld        = live && scl_rise && (st_q == ST_ALO) && (bit_q == 4'd7);
  assign inc_full  = live && scl_rise && (st_q == ST_RD) && (bit_q == 4'd7);
  assign inc_page  = wvalid_q && wr_ready_i;

  eep_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ADDR_W'({ahi_q, rx_next})),
    .inc_page(inc_page), .inc_full(inc_full), .addr_o(addr)
  );

  always_comb begin
    if (st_q == ST_RD) target = mack_q ? ST_RD : ST_IDLE;
    else               target = nxt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      nxt_q     <= ST_IDLE;
      bit_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      ahi_q     <= '0;
      wdat_q    <= '0;
      ack_q     <= 1'b0;
      sda_low_q <= 1'b0;
      wvalid_q  <= 1'b0;
      commit_q  <= 1'b0;
      armed_q   <= 1'b0;
      mack_q    <= 1'b0;
    end else begin
      wvalid_q <= 1'b0;
      commit_q <= 1'b0;
      if (start_w) begin
        st_q      <= ST_SEL;
        bit_q     <= '0;
        sda_low_q <= 1'b0;
        armed_q   <= 1'b0;
      end else if (stop_w) begin
        st_q      <= ST_IDLE;
        bit_q     <= '0;
        sda_low_q <= 1'b0;
        commit_q  <= armed_q;
        armed_q   <= 1'b0;
      end else if (st_q != ST_IDLE) begin
        if (scl_rise) begin
          if (bit_q < 4'd8) begin
            bit_q <= bit_q + 4'd1;
            rx_q  <= rx_next;
            if (bit_q == 4'd7) begin
              case (st_q)
                ST_SEL: begin
                  ack_q <= sel_match;
                  if (!sel_match)     nxt_q <= ST_IDLE;
                  else if (rx_next[0]) nxt_q <= ST_RD;
                  else                 nxt_q <= ST_AHI;
                end
                ST_AHI: begin
                  ack_q <= 1'b1;
                  ahi_q <= rx_next;
                  nxt_q <= ST_ALO;
                end
                ST_ALO: begin
                  ack_q <= 1'b1;
                  nxt_q <= ST_WDAT;
                end
                ST_WDAT: begin
                  ack_q    <= 1'b0;
                  wvalid_q <= !wr_protect_i;
                  wdat_q   <= rx_next;
                  nxt_q    <= ST_WDAT;
                end
                default: begin
                  ack_q <= 1'b0;
                  nxt_q <= ST_RD;
                end
              endcase
            end
          end else if (bit_q == 4'd8) begin
            bit_q  <= 4'd9;
            mack_q <= !sda_s;
          end
        end else if (scl_fall) begin
          armed_q <= 1'b0;
          if (bit_q == 4'd8) begin
            sda_low_q <= ack_q;
          end else if (bit_q == 4'd9) begin
            bit_q   <= '0;
            st_q    <= target;
            armed_q <= (st_q == ST_WDAT) && ack_q;
            if (target == ST_RD) begin
              tx_q      <= rd_data_i;
              sda_low_q <= ~rd_data_i[7];
            end else begin
              sda_low_q <= 1'b0;
            end
          end else if (st_q == ST_RD && bit_q != 4'd0) begin
            tx_q      <= {tx_q[6:0], 1'b0};
            sda_low_q <= ~tx_q[6];
          end
        end
        if (inc_page) ack_q <= 1'b1;
      end
    end
  end

  assign sda_low_o   = sda_low_q;
  assign wr_valid_o  = wvalid_q;
  assign wr_data_o   = wdat_q;
  assign wr_addr_o   = addr;
  assign rd_addr_o   = addr;
  assign wr_commit_o = commit_q;

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !sda_low_q);

  assert_sda_moves_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!start_w && !stop_w) && (sda_low_q != $past(sda_low_q))) |-> !scl_s);

  assert_offer_in_ack_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid_q |-> (st_q == ST_WDAT && bit_q == 4'd8));

  assert_protect_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid_q |-> $past(!wr_protect_i));

  assert_commit_on_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> (st_q == ST_IDLE && !sda_low_q));
endmodule

// File: tb/eep_i2c_target_tb.sv
module eep_i2c_target_tb;
  localparam int AW = 8;
  localparam int PW = 3;
  localparam int Q  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic wr_protect = 1'b0, busy = 1'b0, wr_ready = 1'b1;
  logic [2:0] ce = 3'b101;
  logic sda_low, wr_valid, wr_commit;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  wire sda_bus = sda_m & ~sda_low;

  always #5 clk = ~clk;

  function automatic logic [7:0] memf(input logic [7:0] a);
    return (a * 8'd29) ^ 8'h5C;
  endfunction
  assign rd_data = memf(rd_addr);

  eep_i2c_target #(.ADDR_W(AW), .PAGE_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_low_o(sda_low),
    .chip_en_i(ce), .wr_protect_i(wr_protect), .wcycle_busy_i(busy),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .wr_commit_o(wr_commit), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  int nvec = 0, nfail = 0, log_n = 0, commit_n = 0, r2_bad = 0;
  logic [7:0] log_a [0:15];
  logic [7:0] log_d [0:15];
  logic prev_low = 1'b0;

  always @(posedge clk) begin
    if (wr_valid && wr_ready && log_n < 16) begin
      log_a[log_n] = wr_addr;
      log_d[log_n] = wr_data;
      log_n++;
    end
    if (wr_commit) commit_n++;
    if (rst_n && (sda_low !== prev_low) && scl_m) r2_bad++;
    prev_low <= sda_low;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = !sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_bits_hi(input logic [7:0] b);
    for (int i = 7; i >= 4; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); b[i] = sda_bus; wq(); scl_m = 0; wq();
    end
    sda_m = !mack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq(); sda_m = 1'b1;
  endtask

  task automatic set_addr(input logic [7:0] a, output bit ok);
    bit a1, a2, a3;
    bus_start();
    send_byte({4'b1010, ce, 1'b0}, a1);
    send_byte(8'h7F, a2);
    send_byte(a, a3);
    ok = a1 & a2 & a3;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  bit ack, ok;
  logic [7:0] d;
  int base_n, base_c;

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 reset sda released", sda_low, 0);
    chk("R5 reset no offer", wr_valid, 0);
    chk("R8 reset no commit", wr_commit, 0);

    // R3: chip-enable field sweep and device type sweep
    for (int c = 0; c < 8; c++) begin
      bus_start(); send_byte({4'b1010, 3'(c), 1'b0}, ack); bus_stop();
      chk("R3 chip enable match", ack, (c == 5));
    end
    for (int t = 0; t < 16; t++) begin
      bus_start(); send_byte({4'(t), ce, 1'b1}, ack);
      if (ack) begin recv_byte(1'b0, d); end
      bus_stop();
      chk("R3 device type match", ack, (t == 10));
    end
    chk("R8 no commit without data", commit_n, 0);

    // R1: stop returns to idle, unstarted byte ignored
    bus_start(); send_byte({4'b1010, ce, 1'b0}, ack); send_byte(8'h00, ack); bus_stop();
    chk("R1 stop released", sda_low, 0);
    send_byte(8'hA0 | {4'b0, ce, 1'b0}, ack);
    chk("R1 idle ignores bytes", ack, 0);
    bus_stop();

    // R4/R5/R8: byte write
    set_addr(8'h34, ok);
    chk("R4 address bytes acked", ok, 1);
    send_byte(8'hA5, ack);
    chk("R5 data acked", ack, 1);
    bus_stop();
    repeat (4) @(negedge clk);
    chk("R5 one offer", log_n, 1);
    chk("R4 offer address", log_a[0], 8'h34);
    chk("R5 offer data", log_d[0], 8'hA5);
    chk("R8 commit after data", commit_n, 1);

    // R5: page write wraps inside the row
    set_addr(8'h3E, ok);
    for (int i = 0; i < 4; i++) begin
      send_byte(8'(8'h10 + i), ack);
      chk("R5 page byte acked", ack, 1);
    end
    bus_stop();
    repeat (4) @(negedge clk);
    chk("R5 page count", log_n, 5);
    for (int i = 0; i < 4; i++) begin
      chk("R5 page address wrap", log_a[1+i], {5'b00111, 3'(3'b110 + 3'(i))});
      chk("R5 page data", log_d[1+i], 8'(8'h10 + i));
    end
    chk("R8 commit count", commit_n, 2);

    // R5: byte refused by the page buffer
    wr_ready = 1'b0;
    set_addr(8'h20, ok);
    send_byte(8'h66, ack);
    chk("R5 not-ready nack", ack, 0);
    bus_stop();
    wr_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 not-ready not logged", log_n, 5);
    chk("R8 no commit after nack", commit_n, 2);

    // R6: write protect
    wr_protect = 1'b1;
    set_addr(8'h44, ok);
    chk("R6 select and address acked", ok, 1);
    send_byte(8'h99, ack);
    chk("R6 data nack", ack, 0);
    send_byte(8'h98, ack);
    chk("R6 second data nack", ack, 0);
    bus_stop();
    wr_protect = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 nothing offered", log_n, 5);
    chk("R8 no commit under protect", commit_n, 2);

    // R7: busy refuses selects, then polling succeeds
    busy = 1'b1;
    bus_start(); send_byte({4'b1010, ce, 1'b0}, ack); bus_stop();
    chk("R7 busy write select nack", ack, 0);
    bus_start(); send_byte({4'b1010, ce, 1'b1}, ack); bus_stop();
    chk("R7 busy read select nack", ack, 0);
    busy = 1'b0;
    bus_start(); send_byte({4'b1010, ce, 1'b0}, ack); bus_stop();
    chk("R7 poll after busy", ack, 1);

    // R9/R10: random read across the top address
    set_addr(8'hFE, ok);
    bus_start();
    send_byte({4'b1010, ce, 1'b1}, ack);
    chk("R10 read select acked", ack, 1);
    for (int i = 0; i < 4; i++) begin
      recv_byte(i != 3, d);
      chk("R9 sequential read rollover", d, memf(8'(8'hFE + i)));
    end
    bus_stop();
    chk("R9 released after nack", sda_low, 0);
    bus_start(); send_byte({4'b1010, ce, 1'b1}, ack);
    recv_byte(1'b0, d); bus_stop();
    chk("R10 current address read", d, memf(8'h02));

    // R11: start inside a data byte aborts it
    base_n = log_n; base_c = commit_n;
    set_addr(8'h10, ok);
    send_bits_hi(8'hF0);
    bus_start();
    send_byte({4'b1010, ce, 1'b1}, ack);
    recv_byte(1'b0, d); bus_stop();
    repeat (4) @(negedge clk);
    chk("R11 address unchanged", d, memf(8'h10));
    chk("R11 nothing offered", log_n, base_n);
    chk("R11 no commit", commit_n, base_c);

    chk("R2 sda only moves with scl low", r2_bad, 0);
    summary();
    $finish;
  end
endmodule